// File: doc/BRIEF.md
# Packet Transmit Stream Protocol Checker

This block is a passive monitor for a 128-bit packet transmit stream. The stream has a valid strobe, start and end markers for packets, a half-beat empty flag and an error flag that nullifies the packet in flight. The checker never drives the stream. It watches every beat. It reports packet framing faults, misuse of the empty flag, and any break of the timing and eligibility rules for nullifying a packet.

Each kind of fault has its own bit. A bit pulses for one cycle in the cycle after the offending beat, and it is also latched into a sticky vector that holds until a synchronous clear. Two saturating counters record how many packets were closed and how many of them were nullified. The stream does not encode the packet kind (posted with payload, completion with payload, other), so a sideband input supplies it. The checker samples that input on the start beat.

Top module: `tx_stream_checker`

## Requirements
- R1: After reset, `viol_sticky`, `viol_pulse`, `pkt_count` and `null_count` are all zero.
- R2: A valid beat with `st_sop` high while a packet is already open sets violation bit 0 (start inside packet). The new start then opens a fresh packet.
- R3: A valid beat without `st_sop` while no packet is open sets violation bit 1 (orphan beat). This covers a stray end beat and a stray middle beat. A valid beat with `st_eop` closes any open packet.
- R4: `st_empty` high on a valid beat without `st_eop` sets violation bit 2. `st_empty` on a valid end beat is legal and means that only data bits [63:0] carry payload.
- R5: `st_err` high on any cycle that is not a valid middle beat of an open packet sets violation bit 3 (nullify outside window). Cycles that count as outside the window are: `st_valid` low, the start beat, the end beat, and no packet open.
- R6: A second `st_err` beat within the same packet sets violation bit 4.
- R7: A packet that ends after 1 or 2 beats and saw `st_err` on any of its beats sets violation bit 5 on its end beat.
- R8: `st_err` in a packet whose kind is 2'b10 (other) or 2'b11 (reserved) sets violation bit 6. 2'b00 (posted with payload) and 2'b01 (completion with payload) may be nullified. The kind is taken from `pkt_kind` on the start beat only.
- R9: A valid start beat on the cycle right after the end beat of a nullified packet sets violation bit 7. With one or more cycles between them, no violation is raised.
- R10: Each violation raises its `viol_pulse` bit for exactly the one cycle after the offending beat and sets the same `viol_sticky` bit at that edge. Sticky bits hold until `clr_viol` is sampled high. A violation detected in the same cycle as the clear stays set.
- R11: `pkt_count` increments on every valid end beat that closes a packet. `null_count` increments when that packet saw `st_err`. Both counters saturate at 16'hFFFF.
- R12: While `st_valid` is low, `st_sop`, `st_eop` and `st_empty` have no effect on violations, counters or packet state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_viol | input | 1 | Synchronous clear of the sticky violation vector |
| st_valid | input | 1 | Beat valid on the monitored stream |
| st_sop | input | 1 | First beat of a packet |
| st_eop | input | 1 | Last beat of a packet |
| st_empty | input | 1 | Upper 64 bits of the end beat carry no payload |
| st_err | input | 1 | Nullify the packet in flight |
| pkt_kind | input | 2 | Sideband packet kind, sampled on the start beat |
| viol_sticky | output | 8 | Latched violation bits |
| viol_pulse | output | 8 | One-cycle violation pulses |
| pkt_count | output | 16 | Saturating count of closed packets |
| null_count | output | 16 | Saturating count of nullified packets |

## Verification
The embedded properties assume that `rst_n` is held low for at least one clock edge before checking begins. They also assume that `clr_viol` and all stream inputs change only away from the rising edge. The bench meets both conditions: it drives every input one time unit after a rising edge and samples at that same point. The properties place no constraint on legal traffic, because the block has to accept and classify any pattern on the stream. The bench therefore drives illegal sequences on purpose. It follows most packets with an idle cycle, so that one scenario's end beat cannot cause a gap violation in the next.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int NUM_VIOL   = 8;
    localparam int NUM_FRAME  = 3;
    localparam int NUM_NULL   = NUM_VIOL - NUM_FRAME;

    // bit positions inside the violation vector
    localparam int V_SOP_OPEN = 0;
    localparam int V_ORPHAN   = 1;
    localparam int V_EMPTY    = 2;
    localparam int V_WINDOW   = 3;
    localparam int V_MULTI    = 4;
    localparam int V_SHORT    = 5;
    localparam int V_KIND     = 6;
    localparam int V_GAP      = 7;

    typedef logic [NUM_VIOL-1:0] viol_t;

    typedef enum logic [1:0] {
        KIND_POSTED = 2'b00,
        KIND_CPL    = 2'b01,
        KIND_OTHER  = 2'b10,
        KIND_RSVD   = 2'b11
    } kind_e;
endpackage

// File: rtl/tsc_frame.sv
module tsc_frame
    import tsc_pkg::*;
#(
    parameter int SHORT_LEN = 2,
    localparam int LEN_W    = $clog2(SHORT_LEN + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid,
    input  logic                 sop,
    input  logic                 eop,
    input  logic                 empty,
    input  logic                 err,
    input  logic [1:0]           kind,
    output logic                 in_pkt,
    output logic                 first_beat,
    output logic                 mid_beat,
    output logic                 last_beat,
    output logic [LEN_W-1:0]     beat_num,
    output logic                 err_before,
    output logic [1:0]           kind_cur,
    output logic [NUM_FRAME-1:0] frame_viol
);
    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(SHORT_LEN + 1);

    typedef struct packed {
        logic             open;
        logic [LEN_W-1:0] beats;
        logic             err_seen;
        logic [1:0]       kind;
    } frame_t;

    frame_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        frame_viol = '0;

        first_beat = valid && sop;
        in_pkt     = first_beat || (valid && !sop && st_q.open);
        last_beat  = in_pkt && eop;
        mid_beat   = in_pkt && !first_beat && !eop;

        if (first_beat) begin
            beat_num = LEN_W'(1);
        end else if (st_q.beats >= LEN_CAP) begin
            beat_num = LEN_CAP;
        end else begin
            beat_num = st_q.beats + LEN_W'(1);
        end
        err_before = first_beat ? 1'b0 : st_q.err_seen;
        kind_cur   = first_beat ? kind : st_q.kind;

        if (valid && sop && st_q.open)   frame_viol[V_SOP_OPEN] = 1'b1;
        if (valid && !sop && !st_q.open) frame_viol[V_ORPHAN]   = 1'b1;
        if (valid && empty && !eop)      frame_viol[V_EMPTY]    = 1'b1;

        if (in_pkt) begin
            st_d.open     = !eop;
            st_d.beats    = beat_num;
            st_d.err_seen = err_before || err;
            st_d.kind     = kind_cur;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    eop_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && eop) |=> !st_q.open);

    // R12
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(st_q.open));
endmodule

// File: rtl/tsc_nullify.sv
module tsc_nullify
    import tsc_pkg::*;
#(
    parameter int SHORT_LEN = 2,
    localparam int LEN_W    = $clog2(SHORT_LEN + 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid,
    input  logic                sop,
    input  logic                err,
    input  logic                in_pkt,
    input  logic                mid_beat,
    input  logic                last_beat,
    input  logic [LEN_W-1:0]    beat_num,
    input  logic                err_before,
    input  logic [1:0]          kind_cur,
    output logic [NUM_NULL-1:0] null_viol,
    output logic                pkt_done,
    output logic                pkt_null
);
    localparam int B_WINDOW = V_WINDOW - NUM_FRAME;
    localparam int B_MULTI  = V_MULTI  - NUM_FRAME;
    localparam int B_SHORT  = V_SHORT  - NUM_FRAME;
    localparam int B_KIND   = V_KIND   - NUM_FRAME;
    localparam int B_GAP    = V_GAP    - NUM_FRAME;

    typedef struct packed {
        logic null_end;
    } null_t;

    null_t st_q, st_d;
    logic  any_err;
    logic  kind_ok;

    always_comb begin
        st_d      = st_q;
        null_viol = '0;

        any_err  = err_before || err;
        kind_ok  = (kind_cur == KIND_POSTED) || (kind_cur == KIND_CPL);
        pkt_done = last_beat;
        pkt_null = last_beat && any_err;

        if (err && !mid_beat)                     null_viol[B_WINDOW] = 1'b1;
        if (err && in_pkt && err_before)          null_viol[B_MULTI]  = 1'b1;
        if (last_beat && any_err &&
            (beat_num <= LEN_W'(SHORT_LEN)))      null_viol[B_SHORT]  = 1'b1;
        if (err && in_pkt && !kind_ok)            null_viol[B_KIND]   = 1'b1;
        if (valid && sop && st_q.null_end)        null_viol[B_GAP]    = 1'b1;

        st_d.null_end = pkt_null;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9
    gap_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.null_end |-> $past(valid));
endmodule

// File: rtl/tsc_counters.sv
module tsc_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_done,
    input  logic             pkt_null,
    output logic [CNT_W-1:0] pkt_count,
    output logic [CNT_W-1:0] null_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] pkts;
        logic [CNT_W-1:0] nuls;
    } cnt_t;

    cnt_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (pkt_done && st_q.pkts != CNT_MAX) st_d.pkts = st_q.pkts + CNT_W'(1);
        if (pkt_null && st_q.nuls != CNT_MAX) st_d.nuls = st_q.nuls + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pkt_count  = st_q.pkts;
    assign null_count = st_q.nuls;

    // R11
    null_le_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.nuls <= st_q.pkts);

    // R11
    pkt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pkts != $past(st_q.pkts)) |-> (st_q.pkts == $past(st_q.pkts) + CNT_W'(1)));
endmodule

// File: rtl/tsc_report.sv
module tsc_report
    import tsc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  viol_t viol_now,
    output viol_t sticky,
    output viol_t pulse
);
    typedef struct packed {
        viol_t sticky;
        viol_t pulse;
    } rep_t;

    rep_t st_q, st_d;

    always_comb begin
        st_d.pulse  = viol_now;
        st_d.sticky = (clr ? '0 : st_q.sticky) | viol_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sticky = st_q.sticky;
    assign pulse  = st_q.pulse;

    // R10
    pulse_in_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pulse & ~st_q.sticky) == '0);

    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> ((st_q.sticky & $past(st_q.sticky)) == $past(st_q.sticky)));
endmodule

// File: rtl/tx_stream_checker.sv
module tx_stream_checker
    import tsc_pkg::*;
#(
    parameter int SHORT_LEN = 2,
    parameter int CNT_W     = 16,
    localparam int LEN_W    = $clog2(SHORT_LEN + 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_viol,
    input  logic                st_valid,
    input  logic                st_sop,
    input  logic                st_eop,
    input  logic                st_empty,
    input  logic                st_err,
    input  logic [1:0]          pkt_kind,
    output logic [NUM_VIOL-1:0] viol_sticky,
    output logic [NUM_VIOL-1:0] viol_pulse,
    output logic [CNT_W-1:0]    pkt_count,
    output logic [CNT_W-1:0]    null_count
);
    logic                 in_pkt;
    logic                 first_beat;
    logic                 mid_beat;
    logic                 last_beat;
    logic [LEN_W-1:0]     beat_num;
    logic                 err_before;
    logic [1:0]           kind_cur;
    logic [NUM_FRAME-1:0] frame_viol;
    logic [NUM_NULL-1:0]  null_viol;
    logic                 pkt_done;
    logic                 pkt_null;
    viol_t                viol_now;

    tsc_frame #(.SHORT_LEN(SHORT_LEN)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (st_valid),
        .sop        (st_sop),
        .eop        (st_eop),
        .empty      (st_empty),
        .err        (st_err),
        .kind       (pkt_kind),
        .in_pkt     (in_pkt),
        .first_beat (first_beat),
        .mid_beat   (mid_beat),
        .last_beat  (last_beat),
        .beat_num   (beat_num),
        .err_before (err_before),
        .kind_cur   (kind_cur),
        .frame_viol (frame_viol)
    );

    tsc_nullify #(.SHORT_LEN(SHORT_LEN)) u_nullify (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (st_valid),
        .sop        (st_sop),
        .err        (st_err),
        .in_pkt     (in_pkt),
        .mid_beat   (mid_beat),
        .last_beat  (last_beat),
        .beat_num   (beat_num),
        .err_before (err_before),
        .kind_cur   (kind_cur),
        .null_viol  (null_viol),
        .pkt_done   (pkt_done),
        .pkt_null   (pkt_null)
    );

    assign viol_now = {null_viol, frame_viol};

    tsc_report u_report (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_viol),
        .viol_now (viol_now),
        .sticky   (viol_sticky),
        .pulse    (viol_pulse)
    );

    tsc_counters #(.CNT_W(CNT_W)) u_counters (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_done   (pkt_done),
        .pkt_null   (pkt_null),
        .pkt_count  (pkt_count),
        .null_count (null_count)
    );

    // R2
    start_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first_beat && !last_beat) |=> !viol_pulse[V_ORPHAN]);

    // R5
    window_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_err && first_beat) |=> viol_pulse[V_WINDOW]);
endmodule

// File: tb/tx_stream_checker_test.sv
module tx_stream_checker_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        clr_viol;
    logic        st_valid, st_sop, st_eop, st_empty, st_err;
    logic [1:0]  pkt_kind;
    logic [7:0]  viol_sticky, viol_pulse;
    logic [15:0] pkt_count, null_count;

    int total = 0;
    int bad   = 0;
    bit finished = 0;
    int exp_pkt  = 0;
    int exp_null = 0;

    tx_stream_checker uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_viol    (clr_viol),
        .st_valid    (st_valid),
        .st_sop      (st_sop),
        .st_eop      (st_eop),
        .st_empty    (st_empty),
        .st_err      (st_err),
        .pkt_kind    (pkt_kind),
        .viol_sticky (viol_sticky),
        .viol_pulse  (viol_pulse),
        .pkt_count   (pkt_count),
        .null_count  (null_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic beat(input logic v, input logic s, input logic e,
                        input logic emp, input logic er, input logic [1:0] k);
        st_valid = v; st_sop = s; st_eop = e; st_empty = emp; st_err = er; pkt_kind = k;
        @(posedge clk); #1;
    endtask

    task automatic idle();
        beat(0, 0, 0, 0, 0, 2'b00);
    endtask

    task automatic clear_sticky();
        clr_viol = 1'b1;
        idle();
        clr_viol = 1'b0;
        chk("R10 cleared sticky", viol_sticky, 8'h00);
    endtask

    task automatic chk_counts(input string tag);
        chk({tag, " pkt_count"}, pkt_count, exp_pkt);
        chk({tag, " null_count"}, null_count, exp_null);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; clr_viol = 1'b0;
        idle(); idle();
        rst_n = 1'b1;
        exp_pkt = 0; exp_null = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 sticky", viol_sticky, 8'h00);
        chk("R1 pulse", viol_pulse, 8'h00);
        chk_counts("R1");
    endtask

    task automatic t_clean();
        beat(1, 1, 0, 0, 0, 2'b00); chk("R5 legal sop", viol_pulse, 8'h00);
        beat(1, 0, 0, 0, 1, 2'b00); chk("R5 legal mid err", viol_pulse, 8'h00);
        beat(1, 0, 1, 0, 0, 2'b00); chk("R7 3-beat nullify ok", viol_pulse, 8'h00);
        exp_pkt++; exp_null++;
        idle();
        beat(1, 1, 0, 0, 0, 2'b01); chk("R9 gap respected", viol_pulse, 8'h00);
        beat(1, 0, 1, 1, 0, 2'b01); chk("R4 empty on eop legal", viol_pulse, 8'h00);
        exp_pkt++;
        idle();
        chk_counts("R11 clean");
        chk("R10 nothing sticky", viol_sticky, 8'h00);
    endtask

    task automatic t_sop_open();
        beat(1, 1, 0, 0, 0, 2'b00);
        beat(1, 1, 0, 0, 0, 2'b00); chk("R2 sop while open", viol_pulse, 8'h01);
        beat(1, 0, 1, 0, 0, 2'b00); chk("R2 restarted packet closes", viol_pulse, 8'h00);
        exp_pkt++;
        idle();
        chk_counts("R2");
        clear_sticky();
    endtask

    task automatic t_orphan();
        beat(1, 0, 0, 0, 0, 2'b00); chk("R3 orphan mid", viol_pulse, 8'h02);
        beat(1, 0, 1, 0, 0, 2'b00); chk("R3 orphan eop", viol_pulse, 8'h02);
        idle();
        chk_counts("R3");
        clear_sticky();
    endtask

    task automatic t_empty();
        beat(1, 1, 0, 0, 0, 2'b00);
        beat(1, 0, 0, 1, 0, 2'b00); chk("R4 empty mid beat", viol_pulse, 8'h04);
        beat(1, 0, 1, 1, 0, 2'b00); chk("R4 empty eop ok", viol_pulse, 8'h00);
        exp_pkt++;
        idle();
        clear_sticky();
    endtask

    task automatic t_window();
        beat(1, 1, 0, 0, 1, 2'b00); chk("R5 err on sop", viol_pulse, 8'h08);
        beat(1, 0, 0, 0, 0, 2'b00);
        beat(1, 0, 0, 0, 0, 2'b00);
        beat(1, 0, 1, 0, 0, 2'b00); chk("R5 long pkt no short", viol_pulse, 8'h00);
        exp_pkt++; exp_null++;
        idle();
        beat(0, 0, 0, 0, 1, 2'b00); chk("R5 err without valid", viol_pulse, 8'h08);
        idle();
        beat(1, 1, 0, 0, 0, 2'b00);
        beat(1, 0, 0, 0, 0, 2'b00);
        beat(1, 0, 0, 0, 0, 2'b00);
        beat(1, 0, 1, 0, 1, 2'b00); chk("R5 err on eop", viol_pulse, 8'h08);
        exp_pkt++; exp_null++;
        idle();
        chk_counts("R11 window");
        clear_sticky();
    endtask

    task automatic t_multi();
        beat(1, 1, 0, 0, 0, 2'b01);
        beat(1, 0, 0, 0, 1, 2'b01); chk("R6 first err ok", viol_pulse, 8'h00);
        beat(1, 0, 0, 0, 1, 2'b01); chk("R6 second err", viol_pulse, 8'h10);
        beat(1, 0, 1, 0, 0, 2'b01);
        exp_pkt++; exp_null++;
        idle();
        clear_sticky();
    endtask

    task automatic t_short();
        beat(1, 1, 0, 0, 0, 2'b00);
        beat(1, 0, 1, 0, 1, 2'b00); chk("R7 two-beat nullify", viol_pulse, 8'h28);
        exp_pkt++; exp_null++;
        idle();
        beat(1, 1, 1, 0, 1, 2'b00); chk("R7 one-beat nullify", viol_pulse, 8'h28);
        exp_pkt++; exp_null++;
        idle();
        chk_counts("R11 short");
        clear_sticky();
    endtask

    task automatic t_kind();
        beat(1, 1, 0, 0, 0, 2'b10);
        beat(1, 0, 0, 0, 1, 2'b00); chk("R8 kind other sampled at sop", viol_pulse, 8'h40);
        beat(1, 0, 1, 0, 0, 2'b00);
        exp_pkt++; exp_null++;
        idle();
        beat(1, 1, 0, 0, 0, 2'b11);
        beat(1, 0, 0, 0, 1, 2'b11); chk("R8 kind reserved", viol_pulse, 8'h40);
        beat(1, 0, 1, 0, 0, 2'b11);
        exp_pkt++; exp_null++;
        idle();
        beat(1, 1, 0, 0, 0, 2'b01);
        beat(1, 0, 0, 0, 1, 2'b10); chk("R8 completion kind ok", viol_pulse, 8'h00);
        beat(1, 0, 1, 0, 0, 2'b10);
        exp_pkt++; exp_null++;
        idle();
        clear_sticky();
    endtask

    task automatic t_gap();
        beat(1, 1, 0, 0, 0, 2'b00);
        beat(1, 0, 0, 0, 1, 2'b00);
        beat(1, 0, 1, 0, 0, 2'b00);
        beat(1, 1, 0, 0, 0, 2'b00); chk("R9 sop right after nullified eop", viol_pulse, 8'h80);
        beat(1, 0, 1, 0, 0, 2'b00);
        exp_pkt += 2; exp_null++;
        beat(1, 1, 0, 0, 0, 2'b00); chk("R9 after clean pkt ok", viol_pulse, 8'h00);
        beat(1, 0, 1, 0, 0, 2'b00);
        exp_pkt++;
        idle();
        chk_counts("R11 gap");
        clear_sticky();
    endtask

    task automatic t_sticky();
        beat(1, 0, 0, 1, 0, 2'b00); chk("R10 pulse both", viol_pulse, 8'h06);
        idle();                     chk("R10 pulse one cycle", viol_pulse, 8'h00);
        idle(); idle();
        chk("R10 sticky held", viol_sticky, 8'h06);
        clr_viol = 1'b1;
        beat(1, 0, 1, 0, 0, 2'b00);
        clr_viol = 1'b0;
        chk("R10 new viol survives clear", viol_sticky, 8'h02);
        clear_sticky();
    endtask

    task automatic t_ignore();
        beat(0, 1, 1, 1, 0, 2'b00); chk("R12 invalid beat no viol", viol_pulse, 8'h00);
        beat(1, 0, 1, 0, 0, 2'b00); chk("R12 invalid sop opened nothing", viol_pulse, 8'h02);
        idle();
        chk_counts("R12");
        clear_sticky();
    endtask

    task automatic t_saturate();
        do_reset();
        for (int i = 0; i < 65540; i++) beat(1, 1, 1, 0, 0, 2'b00);
        idle();
        chk("R11 pkt_count saturates", pkt_count, 16'hFFFF);
        chk("R11 null_count untouched", null_count, 16'h0000);
        chk("R11 no violation in run", viol_sticky, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        st_valid = 0; st_sop = 0; st_eop = 0; st_empty = 0; st_err = 0;
        pkt_kind = 2'b00; clr_viol = 0; rst_n = 0;
        #1;
        t_reset();
        t_clean();
        t_sop_open();
        t_orphan();
        t_empty();
        t_window();
        t_multi();
        t_short();
        t_kind();
        t_gap();
        t_sticky();
        t_ignore();
        t_saturate();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule